// File: doc/BRIEF.md
# Power-Mode Strap and Suspend Indicator Pad Controller

This block runs one bidirectional pad that does two jobs, one after the other. While reset is asserted, and for a while after it is released, the pad stays an input. An external pull resistor holds it at a level, and that level picks the port power-management mode: a high level selects grouped (gang) power switching and a low level selects per-port (individual) switching. The level is read a fixed time after reset is released. Three consecutive samples are taken and a majority vote decides the result, so one noisy sample does not pick the wrong mode. The chosen mode is then held until the next reset.

Once a much longer release delay has passed, the block enables the pad driver. From then on the pad shows the global suspend state. The polarity of that signal is the opposite of the strapped level, so it always drives against the external pull. In gang mode the pad reads low in normal operation and high in suspend. In individual mode it reads high in normal operation and low in suspend. Both delays are given in microseconds and converted to clock cycles from the clock frequency parameter. Any new reset returns the pad to input and starts both delays over.

Top module: `strap_pad_ctrl`

## Requirements
- R1: One clock edge with `rst` high sets `pad_oe` to 0, `pad_out` to 0 and `mode_gang` to 0.
- R2: Number the clock edges after reset release from 1. With S = strap delay in cycles, `pad_in` is sampled at edges S-2, S-1 and S. After edge S, `mode_gang` holds the majority of the three samples (1 = gang, 0 = individual).
- R3: `pad_in` has no effect on `mode_gang` at any edge other than the three sample edges. This holds both before the window and after it, including after the driver is enabled.
- R4: With R = release delay in cycles, `pad_oe` stays 0 through edge R-1 and becomes 1 at edge R. This holds even if `suspend` is high earlier.
- R5: Once `pad_oe` is 1 it stays 1 until the next reset.
- R6: In gang mode, `pad_out` equals the `suspend` value sampled at the previous clock edge.
- R7: In individual mode, `pad_out` is the inverse of the `suspend` value sampled at the previous clock edge.
- R8: A reset asserted at any time, including between the strap time and the release time, clears the mode and restarts both delays from edge 1 of the new release.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pad_in | input | 1 | Level read back from the pad |
| suspend | input | 1 | Global suspend state, 1 = suspended |
| pad_oe | output | 1 | Pad driver enable, 1 = drive |
| pad_out | output | 1 | Value driven onto the pad |
| mode_gang | output | 1 | Latched mode, 1 = gang, 0 = individual |

## Verification
Some properties are checked by assertions on every cycle:
- the three sample taps are never active together;
- the counter never passes its saturation value;
- the driver enable never rises before the release count is reached, and never falls while reset is low;
- the latched mode stays frozen once the strap window has closed;
- the pad value follows the suspend input with the polarity set by the mode.

Other behaviour can only be shown by the bench's scenarios. These are the exact edge numbers of the sample window and the release. They also include the result of the vote for every three-sample pattern, with noise on the pad outside the window. Finally, they show that a reset in mid-sequence restarts the timing from zero.

// File: rtl/strap_pad_pkg.sv
package strap_pad_pkg;

  typedef enum logic {
    MODE_INDIV = 1'b0,
    MODE_GANG  = 1'b1
  } pwr_mode_e;

  // Convert a delay in microseconds to clock cycles
  function automatic int unsigned us_to_cycles(input int unsigned clk_hz,
                                               input int unsigned usec);
    return (clk_hz / 1000) * usec / 1000;
  endfunction

  function automatic logic vote3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/strap_phase_timer.sv
module strap_phase_timer #(
  parameter int unsigned STRAP_CYC   = 240,
  parameter int unsigned RELEASE_CYC = 600000,
  parameter int unsigned CW          = $clog2(RELEASE_CYC + 1)
) (
  input  logic       clk,
  input  logic       rst,
  output logic [2:0] sample_tap,
  output logic       strap_done,
  output logic       release_hit,
  output logic       release_done
);

  localparam logic [CW-1:0] REL_LAST = CW'(RELEASE_CYC);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                  cnt_q <= '0;
    else if (cnt_q != REL_LAST) cnt_q <= cnt_q + 1'b1;
  end

  genvar gi;
  generate
    for (gi = 0; gi < 3; gi++) begin : g_tap
      assign sample_tap[gi] = (cnt_q == CW'(STRAP_CYC - 3 + gi));
    end
  endgenerate

  assign strap_done   = (cnt_q >= CW'(STRAP_CYC));
  assign release_hit  = (cnt_q == CW'(RELEASE_CYC - 1));
  assign release_done = (cnt_q == REL_LAST);

  // R2
  tap_onehot_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(sample_tap));

  // R4
  cnt_sat_chk: assert property (@(posedge clk) disable iff (rst)
    release_done |=> release_done);

endmodule

// File: rtl/strap_sampler.sv
module strap_sampler
  import strap_pad_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       pad_in,
  input  logic [2:0] sample_tap,
  input  logic       strap_done,
  output pwr_mode_e  mode
);

  logic [1:0] early_q;

  genvar gi;
  generate
    for (gi = 0; gi < 2; gi++) begin : g_early
      always_ff @(posedge clk) begin
        if (rst)                 early_q[gi] <= 1'b0;
        else if (sample_tap[gi]) early_q[gi] <= pad_in;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst)                mode <= MODE_INDIV;
    else if (sample_tap[2]) mode <= pwr_mode_e'(vote3(early_q[0], early_q[1], pad_in));
  end

  // R3
  mode_frozen_chk: assert property (@(posedge clk) disable iff (rst)
    (strap_done && $past(strap_done)) |-> $stable(mode));

endmodule

// File: rtl/suspend_driver.sv
module suspend_driver
  import strap_pad_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      suspend,
  input  pwr_mode_e mode,
  input  logic      release_hit,
  input  logic      release_done,
  output logic      pad_oe,
  output logic      pad_out
);

  always_ff @(posedge clk) begin
    if (rst) begin
      pad_oe  <= 1'b0;
      pad_out <= 1'b0;
    end else begin
      pad_oe  <= pad_oe | release_hit;
      pad_out <= (mode == MODE_GANG) ? suspend : ~suspend;
    end
  end

  // R4
  oe_early_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe |-> release_done);

  // R5
  oe_hold_chk: assert property (@(posedge clk) disable iff (rst)
    pad_oe |=> pad_oe);

  // R6 R7
  polarity_chk: assert property (@(posedge clk) disable iff (rst)
    (pad_oe && $past(pad_oe)) |-> (pad_out == ((mode == MODE_GANG) ? $past(suspend) : !$past(suspend))));

endmodule

// File: rtl/strap_pad_ctrl.sv
module strap_pad_ctrl
  import strap_pad_pkg::*;
#(
  parameter int unsigned CLK_HZ     = 12_000_000,
  parameter int unsigned STRAP_US   = 20,
  parameter int unsigned RELEASE_US = 50_000
) (
  input  logic clk,
  input  logic rst,
  input  logic pad_in,
  input  logic suspend,
  output logic pad_oe,
  output logic pad_out,
  output logic mode_gang
);

  localparam int unsigned STRAP_CYC   = us_to_cycles(CLK_HZ, STRAP_US);
  localparam int unsigned RELEASE_CYC = us_to_cycles(CLK_HZ, RELEASE_US);
  localparam int unsigned CW          = $clog2(RELEASE_CYC + 1);

  logic [2:0] sample_tap;
  logic       strap_done, release_hit, release_done;
  pwr_mode_e  mode;

  strap_phase_timer #(
    .STRAP_CYC  (STRAP_CYC),
    .RELEASE_CYC(RELEASE_CYC),
    .CW         (CW)
  ) u_timer (
    .clk         (clk),
    .rst         (rst),
    .sample_tap  (sample_tap),
    .strap_done  (strap_done),
    .release_hit (release_hit),
    .release_done(release_done)
  );

  strap_sampler u_sampler (
    .clk       (clk),
    .rst       (rst),
    .pad_in    (pad_in),
    .sample_tap(sample_tap),
    .strap_done(strap_done),
    .mode      (mode)
  );

  suspend_driver u_drv (
    .clk         (clk),
    .rst         (rst),
    .suspend     (suspend),
    .mode        (mode),
    .release_hit (release_hit),
    .release_done(release_done),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out)
  );

  assign mode_gang = (mode == MODE_GANG);

  // R1 R8
  reset_clear_chk: assert property (@(posedge clk)
    rst |=> (!pad_oe && !mode_gang && !pad_out));

endmodule

// File: tb/sim_strap_pad_ctrl.sv
module sim_strap_pad_ctrl;

  localparam int S = 20;   // 1 MHz, 20 us
  localparam int R = 200;  // 1 MHz, 200 us

  // {expected mode, sample at S, sample at S-1, sample at S-2}
  localparam logic [3:0] VEC [8] = '{
    4'b0_000, 4'b0_001, 4'b0_010, 4'b1_011,
    4'b0_100, 4'b1_101, 4'b1_110, 4'b1_111
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic pad_in = 1'b0;
  logic suspend = 1'b0;
  logic pad_oe, pad_out, mode_gang;
  int   n_chk = 0;
  int   n_err = 0;
  logic finished = 1'b0;

  always #5 clk = ~clk;

  strap_pad_ctrl #(.CLK_HZ(1_000_000), .STRAP_US(20), .RELEASE_US(200)) u0 (
    .clk(clk), .rst(rst), .pad_in(pad_in), .suspend(suspend),
    .pad_oe(pad_oe), .pad_out(pad_out), .mode_gang(mode_gang)
  );

  task automatic chk(input string req, input logic act, input logic exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %b expected %b at %0t", req, act, exp, $time);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R1 oe", pad_oe, 1'b0);
    chk("R1 out", pad_out, 1'b0);
    chk("R1 mode", mode_gang, 1'b0);
    rst = 1'b0;  // next posedge is edge 1
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++; n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    for (int v = 0; v < 8; v++) begin
      logic exp_m;
      exp_m = VEC[v][3];
      suspend = 1'b0;
      do_reset();
      for (int e = 1; e <= S; e++) begin
        if (e == S - 2)      pad_in = VEC[v][0];
        else if (e == S - 1) pad_in = VEC[v][1];
        else if (e == S)     pad_in = VEC[v][2];
        else                 pad_in = ~exp_m;  // R3 noise outside window
        @(negedge clk);
      end
      chk("R2 vote", mode_gang, exp_m);
      chk("R4 oe at strap", pad_oe, 1'b0);
      suspend = 1'b1;  // early suspend
      for (int e = S + 1; e <= R - 1; e++) begin
        pad_in = e[0];
        @(negedge clk);
      end
      chk("R4 oe before release", pad_oe, 1'b0);
      chk("R3 mode held", mode_gang, exp_m);
      @(negedge clk);  // edge R
      chk("R4 oe at release", pad_oe, 1'b1);
      chk(exp_m ? "R6 suspend out" : "R7 suspend out", pad_out, exp_m ? 1'b1 : 1'b0);
      suspend = 1'b0;
      @(negedge clk);
      chk(exp_m ? "R6 normal out" : "R7 normal out", pad_out, exp_m ? 1'b0 : 1'b1);
      for (int k = 0; k < 10; k++) begin
        pad_in = ~pad_in;
        suspend = k[0];
        @(negedge clk);
        chk("R5 oe held", pad_oe, 1'b1);
        chk("R3 mode after", mode_gang, exp_m);
        chk(exp_m ? "R6 track" : "R7 track", pad_out, exp_m ? k[0] : ~k[0]);
      end
    end

    // R8: reset between strap and release restarts both delays
    pad_in = 1'b1;
    do_reset();
    for (int e = 1; e <= 100; e++) @(negedge clk);
    chk("R8 gang before restart", mode_gang, 1'b1);
    pad_in = 1'b0;
    do_reset();
    chk("R8 mode cleared", mode_gang, 1'b0);
    for (int e = 1; e <= R - 1; e++) @(negedge clk);
    chk("R8 oe restarted", pad_oe, 1'b0);
    chk("R8 restrapped", mode_gang, 1'b0);
    @(negedge clk);
    chk("R8 oe at new release", pad_oe, 1'b1);

    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  end

endmodule